// File: doc/BRIEF.md
# Periodic ADC Conversion Sequencer with Serial Readout

This block sits on the host side of a serial slave analog-to-digital converter. A periodic timer event fires a one-cycle convert strobe. The block then waits for the converter's busy line to drop. That falling edge, and not a busy level, starts the readout.

The 16-bit result is read as two 8-bit transfers, most significant byte first. The serial clock idles low, and the host captures each bit on the falling (second) edge of each clock period. The converter drives the next bit after each rising edge. Chip select and read enable go low together when readout begins, stay low across both bytes, and are released after the 16th bit. The assembled word leaves on a data output with a one-cycle valid strobe.

The output stream has no ready input and so no back-pressure: the consumer must take the word in the strobe cycle. The word stays on the data output until the next readout begins. A timer event that arrives while a conversion or readout is in flight is not started. Instead it raises a one-cycle overrun pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are in this state: convert strobe low, chip select high, read enable high, serial clock low, valid low, overrun low.
- R2: A timer event sampled while the sequencer is idle produces a convert strobe that is high for exactly the next clock cycle.
- R3: Readout starts only on a high-to-low transition of busy after a convert strobe. Chip select goes low in the cycle after the first clock edge that samples busy low. A busy pulse while idle leaves chip select high and the serial clock low.
- R4: Chip select and read enable are always equal. They are never low while busy is high. They return high in the same cycle that valid rises.
- R5: The half-period length DIV equals the divisor input, with 0 treated as 1. It is latched when readout starts, so later changes to the input do not affect it. Each serial clock high phase lasts DIV cycles, and each low phase inside a byte lasts DIV cycles. The first rise comes DIV cycles after chip select falls.
- R6: Sixteen bits are captured on falling serial clock edges, most significant bit first. The bit the converter presents after the k-th rising edge becomes bit 16-k of the word.
- R7: The two bytes are separated by an extra low gap. The low time between the 8th fall and the 9th rise is 2*DIV cycles.
- R8: Valid is a one-cycle pulse, and the data output carries the assembled word in that cycle.
- R9: A timer event sampled while the sequencer is not idle produces a one-cycle overrun pulse in the next cycle and no convert strobe.
- R10: A timer event sampled in the cycle where valid is high is accepted as a new conversion, not counted as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic timer event |
| div_i | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| busy_i | input | 1 | Converter busy flag |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | One-cycle convert start strobe |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read enable |
| sclk_o | output | 1 | Serial clock, idles low |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_o | output | WORD_W | Assembled result, MSB first |
| overrun_o | output | 1 | One-cycle pulse for a refused timer event |

## Verification
Word delivery and a timer event can meet in the same cycle. The outcome depends on which edge samples the event. An event on the edge that captures the 16th bit finds the sequencer still busy and must give an overrun. An event one cycle later, in the valid cycle, must start a new conversion. The bench drives an event exactly in the cycle where it observes valid high, and it also throws events at random phases across the whole read. It judges each sampled event from its own view of whether a transfer was in flight when the event was sampled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_READ = 2'd2,
    SQ_GAP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_fall_det.sv
module adc_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  // High in the cycle where the sampled level has just dropped
  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lat_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lat_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      lat_q <= (div_i == '0) ? DIV_W'(1) : div_i;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (clr_i)   data_q <= '0;
    else if (shift_i) data_q <= {data_q[W-2:0], bit_i};
  end

  assign data_o = data_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              busy_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              sclk_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              overrun_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int SUB_W = $clog2(BYTE_W);

  seq_state_t       state_q;
  logic [CNT_W-1:0] bit_q;
  logic             sclk_q, cnv_q, cs_q, rd_q, valid_q, ovr_q;
  logic             busy_fall, half_tick, start_rd, shift_en;
  logic             last_bit, byte_end;

  adc_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (busy_i),
    .fall_o (busy_fall)
  );

  assign start_rd = (state_q == SQ_WAIT) && busy_fall;

  adc_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_rd),
    .run_i  ((state_q == SQ_READ) || (state_q == SQ_GAP)),
    .div_i  (div_i),
    .tick_o (half_tick)
  );

  // Capture on the second (falling) edge of each serial clock period
  assign shift_en = (state_q == SQ_READ) && half_tick && sclk_q;

  adc_shift_in #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_rd),
    .shift_i (shift_en),
    .bit_i   (sdo_i),
    .data_o  (word_o)
  );

  assign last_bit = (bit_q == CNT_W'(WORD_W - 1));
  assign byte_end = (bit_q[SUB_W-1:0] == SUB_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cnv_q   <= 1'b0;
      cs_q    <= 1'b0;
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      cnv_q   <= 1'b0;
      valid_q <= 1'b0;
      ovr_q   <= tick_i && (state_q != SQ_IDLE);
      case (state_q)
        SQ_IDLE: begin
          if (tick_i) begin
            cnv_q   <= 1'b1;
            state_q <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (busy_fall) begin
            cs_q    <= 1'b1;
            rd_q    <= 1'b1;
            bit_q   <= '0;
            state_q <= SQ_READ;
          end
        end
        SQ_READ: begin
          if (half_tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              bit_q  <= bit_q + CNT_W'(1);
              if (last_bit) begin
                cs_q    <= 1'b0;
                rd_q    <= 1'b0;
                valid_q <= 1'b1;
                bit_q   <= '0;
                state_q <= SQ_IDLE;
              end else if (byte_end) begin
                state_q <= SQ_GAP;
              end
            end
          end
        end
        SQ_GAP: begin
          if (half_tick) state_q <= SQ_READ;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign cnv_o        = cnv_q;
  assign cs_n_o       = ~cs_q;
  assign rd_n_o       = ~rd_q;
  assign sclk_o       = sclk_q;
  assign word_valid_o = valid_q;
  assign overrun_o    = ovr_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic busy_i,
  input logic cnv_o,
  input logic cs_n_o,
  input logic rd_n_o,
  input logic sclk_o,
  input logic word_valid_o,
  input logic overrun_o
);
  assert_cnv_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |=> !cnv_o);
  assert_cnv_not_reading_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> cs_n_o);
  assert_cs_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !busy_i);
  assert_rd_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !busy_i);
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  assert_release_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $rose(cs_n_o) && $rose(rd_n_o));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(tick_i) && !cnv_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .busy_i       (busy_i),
  .cnv_o        (cnv_o),
  .cs_n_o       (cs_n_o),
  .rd_n_o       (rd_n_o),
  .sclk_o       (sclk_o),
  .word_valid_o (word_valid_o),
  .overrun_o    (overrun_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  div_i = 8'd1;
  logic        busy_i = 1'b0;
  logic        sdo_i = 1'b0;
  logic        cnv_o, cs_n_o, rd_n_o, sclk_o, word_valid_o, overrun_o;
  logic [15:0] word_o;

  always #4 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .div_i(div_i),
    .busy_i(busy_i), .sdo_i(sdo_i), .cnv_o(cnv_o), .cs_n_o(cs_n_o),
    .rd_n_o(rd_n_o), .sclk_o(sclk_o), .word_valid_o(word_valid_o),
    .word_o(word_o), .overrun_o(overrun_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit active = 0, tick_prev = 0, tick_prev_v = 0, tick_on_valid = 0, mid_div = 0;
  bit sclk_prev = 0, cs_prev = 1, valid_prev = 0;
  int busy_left = 0, fall_age = 1000, rises = 0, falls = 0, hi_w = 0, lo_w = 0;
  int div_exp = 1, words = 0;
  logic [15:0] sample = '0;

  function automatic int eff_div(input logic [7:0] d);
    return (d == 8'd0) ? 1 : int'(d);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit t);
    bit act_before, t_eff;
    @(negedge clk);
    act_before = active;
    if (fall_age < 1000) fall_age++;
    // Outcome of the timer event sampled at the edge just passed
    if (tick_prev) begin
      if (act_before) chk(overrun_o && !cnv_o, "R9 refused tick", {overrun_o, cnv_o}, 2);
      else if (tick_prev_v) chk(cnv_o && !overrun_o, "R10 tick in valid cycle", {overrun_o, cnv_o}, 1);
      else chk(cnv_o && !overrun_o, "R2 accepted tick", {overrun_o, cnv_o}, 1);
    end else begin
      chk(!cnv_o && !overrun_o, "R2 no tick no strobe", {overrun_o, cnv_o}, 0);
    end
    // Converter model
    if (cnv_o) begin
      active = 1; busy_i = 1; busy_left = $urandom_range(2, 12);
      sample = 16'($urandom); rises = 0; falls = 0;
    end else if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0) begin
        busy_i = 0; fall_age = 0; div_exp = eff_div(div_i);
      end
    end
    if (!cs_n_o || !rd_n_o) chk(cs_n_o == rd_n_o && !busy_i, "R4 select pair", {cs_n_o, rd_n_o, busy_i}, 0);
    if (!cs_n_o && cs_prev) begin
      chk(fall_age == 1, "R3 select after busy fall", fall_age, 1);
      lo_w = 1;
      if (mid_div) div_i = 8'($urandom_range(0, 9));
    end else if (!cs_n_o) begin
      if (sclk_o && !sclk_prev) begin
        rises++;
        if (rises == 9) chk(lo_w == 2 * div_exp, "R7 byte gap", lo_w, 2 * div_exp);
        else chk(lo_w == div_exp, "R5 low phase", lo_w, div_exp);
        lo_w = 0; hi_w = 1;
        if (rises <= 16) sdo_i = sample[16 - rises];
      end else if (!sclk_o && sclk_prev) begin
        falls++;
        chk(hi_w == div_exp, "R5 high phase", hi_w, div_exp);
        hi_w = 0; lo_w = 1;
      end else if (sclk_o) hi_w++;
      else lo_w++;
    end else if (sclk_prev) begin
      falls++;
      chk(hi_w == div_exp, "R5 last high phase", hi_w, div_exp);
    end
    if (word_valid_o) begin
      chk(word_o == sample, "R6 word value", word_o, sample);
      chk(rises == 16 && falls == 16, "R6 sixteen bits", rises, 16);
      chk(cs_n_o && rd_n_o, "R4 release", {cs_n_o, rd_n_o}, 3);
      chk(!valid_prev, "R8 single strobe", valid_prev, 0);
      active = 0; words++;
    end
    sclk_prev = sclk_o; cs_prev = cs_n_o; valid_prev = word_valid_o;
    t_eff = t | (tick_on_valid & word_valid_o);
    tick_prev_v = tick_on_valid & word_valid_o;
    tick_i = t_eff; tick_prev = t_eff;
  endtask

  task automatic run_conv(input logic [7:0] d, input bit rnd);
    int start, guard;
    div_i = d; start = words; guard = 0;
    cyc(1);
    while (words == start && guard < 8000) begin
      cyc(rnd && ($urandom_range(0, 15) == 0));
      guard++;
    end
    chk(words != start, "R8 word delivered", words - start, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!cnv_o && cs_n_o && rd_n_o && !sclk_o && !word_valid_o && !overrun_o,
        "R1 in reset", {cnv_o, cs_n_o, rd_n_o, sclk_o, word_valid_o, overrun_o}, 6'b011000);
    rst_n = 1;
    repeat (3) cyc(0);
    chk(!cnv_o && cs_n_o && rd_n_o && !sclk_o && !word_valid_o && !overrun_o,
        "R1 after reset", {cnv_o, cs_n_o, rd_n_o, sclk_o, word_valid_o, overrun_o}, 6'b011000);

    // Directed divisors, including zero treated as one
    run_conv(8'd1, 0);
    run_conv(8'd0, 0);
    run_conv(8'd4, 0);
    mid_div = 1;               // R5: divisor changed after readout begins
    run_conv(8'd7, 0);
    mid_div = 0;
    repeat (3) cyc(0);

    // R9: back-to-back ticks and a tick in the middle of the read
    div_i = 8'd2;
    cyc(1); cyc(1);
    while (rises < 5 || !active) cyc(0);
    cyc(1);
    while (active) cyc(0);
    repeat (2) cyc(0);

    // R10: tick exactly in the valid cycle is accepted, then finish that one
    tick_on_valid = 1;
    run_conv(8'd3, 0);
    tick_on_valid = 0;
    while (!active) cyc(0);
    while (active) cyc(0);
    repeat (3) cyc(0);

    // R3: busy pulse while idle must not start a readout
    busy_i = 1;
    repeat (3) cyc(0);
    busy_i = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(0);
      chk(cs_n_o && !sclk_o, "R3 idle busy pulse ignored", {cs_n_o, sclk_o}, 2);
    end

    // Random divisors and random tick phases
    for (int k = 0; k < 30; k++) begin
      run_conv(8'($urandom_range(0, 6)), 1);
    end
    while (active) cyc(0);
    repeat (4) cyc(0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule